// File: doc/BRIEF.md
# Accumulator ALU Core

This block is the combinational execution stage of an 8-bit accumulator processor. Each cycle the surrounding core hands it an opcode byte, the current accumulator, one operand byte that the fetch logic has already gathered (register, immediate or memory contents), and the current carry flag. The block returns the computed byte, new sign, zero and carry values, a per-flag write mask, a code naming where the result belongs, and a flag saying whether the opcode is an ALU operation at all.

The opcode's upper five bits choose the operation group: add-with-carry, AND, OR, exclusive-OR, increment, decrement, rotate left or rotate right through carry. The lower three bits choose the operand source. A handful of single-byte codes handle carry set/clear, clearing the accumulator with Z set, and testing the accumulator for zero. Codes inside these groups that belong to other instructions are reported as not valid. The block holds no state and writes nothing; the caller acts on the destination code and the write mask.

Top module: `accalu_core`

## Requirements
- R1: Opcodes 0100_0sss add the operand, the accumulator and carry_i; result_o is the low 8 bits, carry_o is the carry out of bit 7, flag_we_o is 111 and dest_o is 000 (accumulator).
- R2: Opcodes 0100_1sss (AND), 0101_0sss (OR) and 0101_1sss (exclusive-OR) combine the operand with the accumulator; flag_we_o is 110, carry_o equals carry_i, dest_o is 000.
- R3: Opcodes 0110_0sss increment and 0110_1sss decrement the operand; flag_we_o is 111 and dest_o equals sss. Increment sets carry_o only when the operand is FF; decrement sets carry_o (borrow) only when the operand is 00.
- R4: Opcodes 0111_0sss rotate left through carry (old carry into bit 0, bit 7 to carry_o); 0111_1sss rotate right (old carry into bit 7, bit 0 to carry_o); flag_we_o is 111, dest_o equals sss.
- R5: When sss is 000 the operand is acc_i and opnd_i has no effect; for sss 001, 010, 011, 100, 110 and 111 the operand is opnd_i. dest_o codes: 000 accumulator, 001 no write, 010 X, 011 Y, 100 direct address, 110 memory at X, 111 memory at Y.
- R6: flag_we_o bit 2 enables sign, bit 1 zero, bit 0 carry. When the sign bit is enabled sign_o is result_o bit 7; when the zero bit is enabled zero_o is 1 exactly when result_o is 00. A disabled sign or zero output is 0; a disabled carry output equals carry_i.
- R7: 0110_0001 drives carry_o to 0 and 0110_0101 drives carry_o to 1; both give flag_we_o 001, dest_o 001, result_o 00.
- R8: 0101_1000 gives result_o 00, zero_o 1, sign_o 0, flag_we_o 110, dest_o 000. 0101_0000 gives result_o equal to acc_i with sign and zero from it, flag_we_o 110 and dest_o 001.
- R9: 0110_1001, 0110_1101, 0111_0001, 0111_0101, 0111_1001, 0111_1101, 0101_0101 and every opcode outside 0100_0000 to 0111_1111 give valid_o 0, flag_we_o 000, dest_o 001, result_o 00 and carry_o equal to carry_i.
- R10: Source code 001 (immediate) is valid only for the add, AND, OR and exclusive-OR groups; source code 101 is valid in no group apart from the carry-set code of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Instruction opcode byte |
| acc_i | input | DATA_W | Current accumulator value |
| opnd_i | input | DATA_W | Pre-fetched operand byte for non-accumulator sources |
| carry_i | input | 1 | Current carry flag |
| result_o | output | DATA_W | Computed result |
| sign_o | output | 1 | New sign flag value |
| zero_o | output | 1 | New zero flag value |
| carry_o | output | 1 | New carry flag value |
| flag_we_o | output | 3 | Flag write mask: bit 2 sign, bit 1 zero, bit 0 carry |
| valid_o | output | 1 | Opcode is an ALU operation |
| dest_o | output | 3 | Result destination code |

## Verification
The bench aims at the wrap points: FF plus a carry-in, incrementing FF and decrementing 00, where a design with a missing carry-in or an inverted borrow sense would report the wrong carry and zero. It rotates patterns with the end bits set against both carry values, which catches swapped directions or a carry inserted at the wrong end. It probes the reserved codes and immediate/101 source codes inside each group, where a loose decoder would raise valid and write flags, and the accumulator source, where picking opnd_i instead of acc_i gives a different sum. A sweep of all 256 opcodes with varied operands then compares every output against an independent model.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

   localparam int OPC_W  = 8;
   localparam int SEL_W  = 3;
   localparam int FLAG_W = 3;

   typedef enum logic [3:0] {
      GRP_NONE,
      GRP_ADC,
      GRP_AND,
      GRP_OR,
      GRP_XOR,
      GRP_INC,
      GRP_DEC,
      GRP_ROL,
      GRP_ROR,
      GRP_CLRC,
      GRP_SETC,
      GRP_SETZ,
      GRP_TZ
   } grp_e;

   typedef enum logic [1:0] {
      AR_OFF,
      AR_ADC,
      AR_INC,
      AR_DEC
   } ar_mode_e;

   typedef enum logic [1:0] {
      LG_AND,
      LG_OR,
      LG_XOR,
      LG_PASS
   } lg_fn_e;

   // operand source codes (low opcode bits)
   localparam logic [SEL_W-1:0] SRC_ACC = 3'b000;
   localparam logic [SEL_W-1:0] SRC_IMM = 3'b001;
   localparam logic [SEL_W-1:0] SRC_BAD = 3'b101;

   // destination codes
   localparam logic [SEL_W-1:0] DEST_ACC  = 3'b000;
   localparam logic [SEL_W-1:0] DEST_NONE = 3'b001;

   // flag write-enable masks {N,Z,C}
   localparam logic [FLAG_W-1:0] WE_NONE = 3'b000;
   localparam logic [FLAG_W-1:0] WE_C    = 3'b001;
   localparam logic [FLAG_W-1:0] WE_NZ   = 3'b110;
   localparam logic [FLAG_W-1:0] WE_NZC  = 3'b111;

   typedef struct packed {
      grp_e               grp;
      logic               valid;
      logic [FLAG_W-1:0]  fwe;
      logic [SEL_W-1:0]   dest;
      logic               use_acc;
   } dec_t;

endpackage

// File: rtl/accalu_decode.sv
module accalu_decode
   import accalu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   output dec_t             dec_o
);

   logic [4:0]       hi;
   logic [SEL_W-1:0] sss;
   grp_e             raw_grp;
   grp_e             grp;
   logic             src_ok;
   logic             takes_imm;

   assign hi  = opcode_i[OPC_W-1:SEL_W];
   assign sss = opcode_i[SEL_W-1:0];

   // group selection from the upper field, with single-byte specials
   always_comb begin
      raw_grp = GRP_NONE;
      case (hi)
         5'b01000: raw_grp = GRP_ADC;
         5'b01001: raw_grp = GRP_AND;
         5'b01010: raw_grp = (sss == SRC_ACC) ? GRP_TZ   : GRP_OR;
         5'b01011: raw_grp = (sss == SRC_ACC) ? GRP_SETZ : GRP_XOR;
         5'b01100: begin
            if (sss == SRC_IMM)      raw_grp = GRP_CLRC;
            else if (sss == SRC_BAD) raw_grp = GRP_SETC;
            else                     raw_grp = GRP_INC;
         end
         5'b01101: raw_grp = GRP_DEC;
         5'b01110: raw_grp = GRP_ROL;
         5'b01111: raw_grp = GRP_ROR;
         default:  raw_grp = GRP_NONE;
      endcase
   end

   // source legality per group
   always_comb begin
      takes_imm = 1'b0;
      case (raw_grp)
         GRP_ADC, GRP_AND, GRP_OR, GRP_XOR: takes_imm = 1'b1;
         default:                           takes_imm = 1'b0;
      endcase
   end

   always_comb begin
      case (raw_grp)
         GRP_CLRC, GRP_SETC, GRP_SETZ, GRP_TZ: src_ok = 1'b1;
         GRP_NONE:                             src_ok = 1'b0;
         default: src_ok = (sss != SRC_BAD) && ((sss != SRC_IMM) || takes_imm);
      endcase
   end

   assign grp = src_ok ? raw_grp : GRP_NONE;

   always_comb begin
      dec_o.grp     = grp;
      dec_o.valid   = (grp != GRP_NONE);
      dec_o.use_acc = (sss == SRC_ACC);
      dec_o.fwe     = WE_NONE;
      dec_o.dest    = DEST_NONE;
      case (grp)
         GRP_ADC: begin
            dec_o.fwe  = WE_NZC;
            dec_o.dest = DEST_ACC;
         end
         GRP_AND, GRP_OR, GRP_XOR, GRP_SETZ: begin
            dec_o.fwe  = WE_NZ;
            dec_o.dest = DEST_ACC;
         end
         GRP_INC, GRP_DEC, GRP_ROL, GRP_ROR: begin
            dec_o.fwe  = WE_NZC;
            dec_o.dest = sss;
         end
         GRP_TZ: begin
            dec_o.fwe  = WE_NZ;
            dec_o.dest = DEST_NONE;
         end
         GRP_CLRC, GRP_SETC: begin
            dec_o.fwe  = WE_C;
            dec_o.dest = DEST_NONE;
         end
         default: begin
            dec_o.fwe  = WE_NONE;
            dec_o.dest = DEST_NONE;
         end
      endcase
   end

   // R9: an opcode that is not an ALU operation requests no writes
   always_comb begin
      if (!$isunknown(opcode_i) && !dec_o.valid)
         assert_invalid_quiet_R9 : assert (dec_o.fwe == WE_NONE && dec_o.dest == DEST_NONE)
            else $error("invalid opcode %h requests writes", opcode_i);
   end

   // R7: carry set/clear codes touch only carry
   always_comb begin
      if (!$isunknown(opcode_i) && opcode_i[7:3] == 5'b01100 && opcode_i[1:0] == 2'b01)
         assert_carry_only_R7 : assert (dec_o.fwe == WE_C && dec_o.valid)
            else $error("carry code %h mask %b", opcode_i, dec_o.fwe);
   end

   // R10: immediate source never reaches the increment/decrement/rotate groups
   always_comb begin
      if (!$isunknown(opcode_i) && sss == SRC_IMM && opcode_i[7:5] == 3'b011)
         assert_no_imm_rmw_R10 : assert (dec_o.dest == DEST_NONE)
            else $error("immediate source used as destination for %h", opcode_i);
   end

endmodule

// File: rtl/accalu_arith.sv
module accalu_arith
   import accalu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CARRY_IMPL = 0   // 0: explicit ripple chain, 1: inferred adder
)(
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              carry_i,
   input  ar_mode_e          mode_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o
);

   logic [DATA_W-1:0] xa;
   logic [DATA_W-1:0] yb;
   logic              cin;
   logic              cout;

   always_comb begin
      xa  = '0;
      yb  = '0;
      cin = 1'b0;
      case (mode_i)
         AR_ADC: begin
            xa  = acc_i;
            yb  = opnd_i;
            cin = carry_i;
         end
         AR_INC: begin
            xa  = opnd_i;
            yb  = '0;
            cin = 1'b1;
         end
         AR_DEC: begin
            xa  = opnd_i;
            yb  = '1;
            cin = 1'b0;
         end
         default: begin
            xa  = '0;
            yb  = '0;
            cin = 1'b0;
         end
      endcase
   end

   generate
      if (CARRY_IMPL == 0) begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum_o[i]    = xa[i] ^ yb[i] ^ chain[i];
            assign chain[i+1]  = (xa[i] & yb[i]) | (chain[i] & (xa[i] ^ yb[i]));
         end
         assign cout = chain[DATA_W];
      end else begin : g_infer
         logic [DATA_W:0] wide;
         assign wide  = {1'b0, xa} + {1'b0, yb} + {{DATA_W{1'b0}}, cin};
         assign sum_o = wide[DATA_W-1:0];
         assign cout  = wide[DATA_W];
      end
   endgenerate

   // decrement reports borrow, i.e. the inverse of the adder carry
   assign carry_o = (mode_i == AR_DEC) ? ~cout : cout;

   // R3: borrow on decrement exactly when the operand is zero
   always_comb begin
      if (!$isunknown(opnd_i) && mode_i == AR_DEC)
         assert_dec_borrow_R3 : assert (carry_o == (opnd_i == '0))
            else $error("borrow %b for operand %h", carry_o, opnd_i);
   end

   // R3: increment carries exactly from the all-ones operand
   always_comb begin
      if (!$isunknown(opnd_i) && mode_i == AR_INC)
         assert_inc_carry_R3 : assert (carry_o == (opnd_i == '1))
            else $error("inc carry %b for operand %h", carry_o, opnd_i);
   end

endmodule

// File: rtl/accalu_logic.sv
module accalu_logic
   import accalu_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  lg_fn_e            fn_i,
   output logic [DATA_W-1:0] res_o
);

   always_comb begin
      case (fn_i)
         LG_AND:  res_o = acc_i & opnd_i;
         LG_OR:   res_o = acc_i | opnd_i;
         LG_XOR:  res_o = acc_i ^ opnd_i;
         default: res_o = acc_i;
      endcase
   end

endmodule

// File: rtl/accalu_rotate.sv
module accalu_rotate #(
   parameter int DATA_W = 8
)(
   input  logic [DATA_W-1:0] val_i,
   input  logic              carry_i,
   input  logic              left_i,
   output logic [DATA_W-1:0] res_o,
   output logic              carry_o
);

   always_comb begin
      if (left_i) begin
         res_o   = {val_i[DATA_W-2:0], carry_i};
         carry_o = val_i[DATA_W-1];
      end else begin
         res_o   = {carry_i, val_i[DATA_W-1:1]};
         carry_o = val_i[0];
      end
   end

   // R4: the bit shifted out lands in carry, the old carry enters the far end
   always_comb begin
      if (!$isunknown({val_i, carry_i, left_i})) begin
         if (left_i)
            assert_rol_ends_R4 : assert (carry_o == val_i[DATA_W-1] && res_o[0] == carry_i)
               else $error("rotate left ends wrong");
         else
            assert_ror_ends_R4 : assert (carry_o == val_i[0] && res_o[DATA_W-1] == carry_i)
               else $error("rotate right ends wrong");
      end
   end

endmodule

// File: rtl/accalu_core.sv
module accalu_core
   import accalu_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CARRY_IMPL = 0
)(
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              sign_o,
   output logic              zero_o,
   output logic              carry_o,
   output logic [FLAG_W-1:0] flag_we_o,
   output logic              valid_o,
   output logic [SEL_W-1:0]  dest_o
);

   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("accalu_core: DATA_W must be at least 2");
      end
      if (CARRY_IMPL != 0 && CARRY_IMPL != 1) begin : g_bad_impl
         $error("accalu_core: CARRY_IMPL must be 0 or 1");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] operand;
   ar_mode_e          ar_mode;
   lg_fn_e            lg_fn;
   logic [DATA_W-1:0] ar_sum;
   logic              ar_c;
   logic [DATA_W-1:0] lg_res;
   logic [DATA_W-1:0] rot_res;
   logic              rot_c;
   logic [DATA_W-1:0] res;
   logic              c_new;

   accalu_decode u_dec (
      .opcode_i (opcode_i),
      .dec_o    (dec)
   );

   assign operand = dec.use_acc ? acc_i : opnd_i;

   always_comb begin
      case (dec.grp)
         GRP_ADC: ar_mode = AR_ADC;
         GRP_INC: ar_mode = AR_INC;
         GRP_DEC: ar_mode = AR_DEC;
         default: ar_mode = AR_OFF;
      endcase
   end

   always_comb begin
      case (dec.grp)
         GRP_AND: lg_fn = LG_AND;
         GRP_OR:  lg_fn = LG_OR;
         GRP_XOR: lg_fn = LG_XOR;
         default: lg_fn = LG_PASS;
      endcase
   end

   accalu_arith #(.DATA_W(DATA_W), .CARRY_IMPL(CARRY_IMPL)) u_arith (
      .acc_i   (acc_i),
      .opnd_i  (operand),
      .carry_i (carry_i),
      .mode_i  (ar_mode),
      .sum_o   (ar_sum),
      .carry_o (ar_c)
   );

   accalu_logic #(.DATA_W(DATA_W)) u_logic (
      .acc_i  (acc_i),
      .opnd_i (operand),
      .fn_i   (lg_fn),
      .res_o  (lg_res)
   );

   accalu_rotate #(.DATA_W(DATA_W)) u_rot (
      .val_i   (operand),
      .carry_i (carry_i),
      .left_i  (dec.grp == GRP_ROL),
      .res_o   (rot_res),
      .carry_o (rot_c)
   );

   always_comb begin
      case (dec.grp)
         GRP_ADC, GRP_INC, GRP_DEC: res = ar_sum;
         GRP_AND, GRP_OR, GRP_XOR:  res = lg_res;
         GRP_ROL, GRP_ROR:          res = rot_res;
         GRP_TZ:                    res = lg_res;
         default:                   res = '0;
      endcase
   end

   always_comb begin
      case (dec.grp)
         GRP_ADC, GRP_INC, GRP_DEC: c_new = ar_c;
         GRP_ROL, GRP_ROR:          c_new = rot_c;
         GRP_CLRC:                  c_new = 1'b0;
         GRP_SETC:                  c_new = 1'b1;
         default:                   c_new = carry_i;
      endcase
   end

   assign result_o  = res;
   assign sign_o    = dec.fwe[2] ? res[MSB] : 1'b0;
   assign zero_o    = dec.fwe[1] ? (res == '0) : 1'b0;
   assign carry_o   = c_new;
   assign flag_we_o = dec.fwe;
   assign valid_o   = dec.valid;
   assign dest_o    = dec.dest;

   // R2: bitwise groups pass the incoming carry and do not enable it
   always_comb begin
      if (!$isunknown({opcode_i, carry_i}) && valid_o && opcode_i[7:5] == 3'b010 && opcode_i[4:3] != 2'b00)
         assert_logic_keeps_carry_R2 : assert (carry_o == carry_i && !flag_we_o[0])
            else $error("bitwise op %h disturbed carry", opcode_i);
   end

   // R6: enabled sign/zero agree with the result leaving the block
   always_comb begin
      if (!$isunknown({opcode_i, acc_i, opnd_i, carry_i}) && flag_we_o[1])
         assert_zero_tracks_result_R6 : assert (zero_o == (result_o == '0))
            else $error("zero %b result %h", zero_o, result_o);
   end

   always_comb begin
      if (!$isunknown({opcode_i, acc_i, opnd_i, carry_i}) && flag_we_o[2])
         assert_sign_tracks_result_R6 : assert (sign_o == result_o[MSB])
            else $error("sign %b result %h", sign_o, result_o);
   end

   // R5: accumulator source ignores the operand port for bitwise AND
   always_comb begin
      if (!$isunknown({opcode_i, acc_i}) && opcode_i == 8'h48)
         assert_acc_source_R5 : assert (result_o == acc_i)
            else $error("A AND A gave %h for %h", result_o, acc_i);
   end

endmodule

// File: tb/accalu_core_tb_top.sv
`timescale 1ns/1ps
module accalu_core_tb_top;

   logic       clk = 1'b0;
   logic [7:0] opcode;
   logic [7:0] acc;
   logic [7:0] opnd;
   logic       cin;
   logic [7:0] result;
   logic       sign, zero, cout;
   logic [2:0] fwe;
   logic       valid;
   logic [2:0] dest;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   accalu_core dut_i (
      .opcode_i  (opcode),
      .acc_i     (acc),
      .opnd_i    (opnd),
      .carry_i   (cin),
      .result_o  (result),
      .sign_o    (sign),
      .zero_o    (zero),
      .carry_o   (cout),
      .flag_we_o (fwe),
      .valid_o   (valid),
      .dest_o    (dest)
   );

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles >= 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   // packed view: {valid, fwe, dest, sign, zero, carry, result}
   function automatic logic [17:0] pack(input logic v, input logic [2:0] w, input logic [2:0] d,
                                        input logic n, input logic z, input logic c, input logic [7:0] r);
      return {v, w, d, n, z, c, r};
   endfunction

   // independent model written from the requirement list
   function automatic logic [17:0] model(input logic [7:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic c);
      logic [2:0] s;
      logic [4:0] h;
      logic [7:0] x, r;
      logic [8:0] t;
      logic v, co;
      logic [2:0] w, d;
      s = op[2:0];
      h = op[7:3];
      x = (s == 3'd0) ? a : b;
      v = 0; r = 8'h00; co = c; w = 3'b000; d = 3'b001;
      case (h)
         5'd8: if (s != 3'd5) begin
            t = {1'b0, a} + {1'b0, x} + {8'h00, c};
            r = t[7:0]; co = t[8]; w = 3'b111; d = 3'b000; v = 1;
         end
         5'd9: if (s != 3'd5) begin r = a & x; w = 3'b110; d = 3'b000; v = 1; end
         5'd10: if (s == 3'd0) begin r = a; w = 3'b110; d = 3'b001; v = 1; end
                else if (s != 3'd5) begin r = a | x; w = 3'b110; d = 3'b000; v = 1; end
         5'd11: if (s == 3'd0) begin r = 8'h00; w = 3'b110; d = 3'b000; v = 1; end
                else if (s != 3'd5) begin r = a ^ x; w = 3'b110; d = 3'b000; v = 1; end
         5'd12: if (s == 3'd1) begin co = 0; w = 3'b001; v = 1; end
                else if (s == 3'd5) begin co = 1; w = 3'b001; v = 1; end
                else begin r = x + 8'd1; co = (x == 8'hFF); w = 3'b111; d = s; v = 1; end
         5'd13: if (s != 3'd1 && s != 3'd5) begin
                   r = x - 8'd1; co = (x == 8'h00); w = 3'b111; d = s; v = 1; end
         5'd14: if (s != 3'd1 && s != 3'd5) begin
                   r = {x[6:0], c}; co = x[7]; w = 3'b111; d = s; v = 1; end
         5'd15: if (s != 3'd1 && s != 3'd5) begin
                   r = {c, x[7:1]}; co = x[0]; w = 3'b111; d = s; v = 1; end
         default: ;
      endcase
      return pack(v, w, d, w[2] ? r[7] : 1'b0, w[1] ? (r == 8'h00) : 1'b0, co, r);
   endfunction

   task automatic check(input string tag, input logic [7:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic c, input logic [17:0] exp);
      logic [17:0] act;
      opcode = op; acc = a; opnd = b; cin = c;
      @(negedge clk);
      act = pack(valid, fwe, dest, sign, zero, cout, result);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s op=%h a=%h b=%h c=%b act=%h exp=%h", tag, op, a, b, c, act, exp);
      end
   endtask

   task automatic t_idle_inputs();
      check("R9 all-zero inputs", 8'h00, 8'h00, 8'h00, 1'b0, pack(0, 3'b000, 3'b001, 0, 0, 0, 8'h00));
   endtask

   task automatic t_add();
      check("R1 FF+00+1", 8'h41, 8'hFF, 8'h00, 1'b1, pack(1, 3'b111, 3'b000, 0, 1, 1, 8'h00));
      check("R1 70+10",   8'h42, 8'h70, 8'h10, 1'b0, pack(1, 3'b111, 3'b000, 1, 0, 0, 8'h80));
      check("R1 Y+carry", 8'h43, 8'h01, 8'h02, 1'b1, pack(1, 3'b111, 3'b000, 0, 0, 0, 8'h04));
   endtask

   task automatic t_bitwise();
      check("R2 AND imm", 8'h49, 8'hF0, 8'h3C, 1'b1, pack(1, 3'b110, 3'b000, 0, 0, 1, 8'h30));
      check("R2 OR zero", 8'h52, 8'h00, 8'h00, 1'b0, pack(1, 3'b110, 3'b000, 0, 1, 0, 8'h00));
      check("R2 XOR",     8'h5A, 8'hAA, 8'h2A, 1'b1, pack(1, 3'b110, 3'b000, 1, 0, 1, 8'h80));
   endtask

   task automatic t_step();
      check("R3 INC FF",   8'h62, 8'h11, 8'hFF, 1'b0, pack(1, 3'b111, 3'b010, 0, 1, 1, 8'h00));
      check("R3 DEC 00",   8'h6C, 8'h11, 8'h00, 1'b0, pack(1, 3'b111, 3'b100, 1, 0, 1, 8'hFF));
      check("R3 DEC 01",   8'h6E, 8'h11, 8'h01, 1'b1, pack(1, 3'b111, 3'b110, 0, 1, 0, 8'h00));
      check("R3 INC 7F",   8'h67, 8'h11, 8'h7F, 1'b1, pack(1, 3'b111, 3'b111, 1, 0, 0, 8'h80));
   endtask

   task automatic t_rotate();
      check("R4 ROL X",    8'h72, 8'h00, 8'h81, 1'b0, pack(1, 3'b111, 3'b010, 0, 0, 1, 8'h02));
      check("R4 ROR Y",    8'h7B, 8'h00, 8'h01, 1'b1, pack(1, 3'b111, 3'b011, 1, 0, 1, 8'h80));
      check("R4 ROL A",    8'h70, 8'h80, 8'h55, 1'b0, pack(1, 3'b111, 3'b000, 0, 1, 1, 8'h00));
      check("R4 ROR (Y)",  8'h7F, 8'hFF, 8'h00, 1'b0, pack(1, 3'b111, 3'b111, 0, 1, 0, 8'h00));
   endtask

   task automatic t_source();
      check("R5 ADC A ignores opnd", 8'h40, 8'h21, 8'hEE, 1'b0, pack(1, 3'b111, 3'b000, 0, 0, 0, 8'h42));
      check("R5 INC A ignores opnd", 8'h60, 8'h05, 8'h99, 1'b0, pack(1, 3'b111, 3'b000, 0, 0, 0, 8'h06));
      check("R5 dest direct",        8'h74, 8'h00, 8'h01, 1'b0, pack(1, 3'b111, 3'b100, 0, 0, 0, 8'h02));
   endtask

   task automatic t_flags();
      check("R6 sign from AND (X)", 8'h4E, 8'h80, 8'h80, 1'b0, pack(1, 3'b110, 3'b000, 1, 0, 0, 8'h80));
      check("R6 disabled N/Z zero", 8'h65, 8'h00, 8'h00, 1'b0, pack(1, 3'b001, 3'b001, 0, 0, 1, 8'h00));
   endtask

   task automatic t_carry_codes();
      check("R7 clear c=1", 8'h61, 8'h33, 8'h44, 1'b1, pack(1, 3'b001, 3'b001, 0, 0, 0, 8'h00));
      check("R7 clear c=0", 8'h61, 8'h33, 8'h44, 1'b0, pack(1, 3'b001, 3'b001, 0, 0, 0, 8'h00));
      check("R7 set c=0",   8'h65, 8'h33, 8'h44, 1'b0, pack(1, 3'b001, 3'b001, 0, 0, 1, 8'h00));
   endtask

   task automatic t_zero_codes();
      check("R8 clear A",   8'h58, 8'h37, 8'h12, 1'b1, pack(1, 3'b110, 3'b000, 0, 1, 1, 8'h00));
      check("R8 test zero", 8'h50, 8'h00, 8'h12, 1'b0, pack(1, 3'b110, 3'b001, 0, 1, 0, 8'h00));
      check("R8 test neg",  8'h50, 8'h90, 8'h12, 1'b1, pack(1, 3'b110, 3'b001, 1, 0, 1, 8'h90));
   endtask

   task automatic t_reserved();
      logic [7:0] codes [7] = '{8'h69, 8'h6D, 8'h71, 8'h75, 8'h79, 8'h7D, 8'h55};
      for (int i = 0; i < 7; i++)
         check("R9 reserved", codes[i], 8'h5A, 8'hA5, 1'b1, pack(0, 3'b000, 3'b001, 0, 0, 1, 8'h00));
      check("R9 outside range", 8'hC3, 8'h5A, 8'hA5, 1'b0, pack(0, 3'b000, 3'b001, 0, 0, 0, 8'h00));
   endtask

   task automatic t_source_codes();
      check("R10 ADC src 101", 8'h45, 8'h01, 8'h01, 1'b0, pack(0, 3'b000, 3'b001, 0, 0, 0, 8'h00));
      check("R10 AND src 101", 8'h4D, 8'h01, 8'h01, 1'b1, pack(0, 3'b000, 3'b001, 0, 0, 1, 8'h00));
      check("R10 EOR src 101", 8'h5D, 8'h01, 8'h01, 1'b0, pack(0, 3'b000, 3'b001, 0, 0, 0, 8'h00));
      check("R10 EOR imm",     8'h59, 8'h0F, 8'hFF, 1'b0, pack(1, 3'b110, 3'b000, 1, 0, 0, 8'hF0));
   endtask

   task automatic t_sweep();
      logic [7:0] a, b;
      logic c;
      for (int op = 0; op < 256; op++) begin
         for (int k = 0; k < 4; k++) begin
            a = 8'($urandom_range(0, 255));
            b = 8'($urandom_range(0, 255));
            c = 1'($urandom_range(0, 1));
            if (k == 0) begin a = 8'hFF; b = 8'h00; end
            if (k == 1) begin a = 8'h00; b = 8'hFF; end
            check("R1/R2/R3/R4 sweep", 8'(op), a, b, c, model(8'(op), a, b, c));
         end
      end
   endtask

   initial begin
      opcode = 8'h00; acc = 8'h00; opnd = 8'h00; cin = 1'b0;
      repeat (2) @(negedge clk);
      t_idle_inputs();
      t_add();
      t_bitwise();
      t_step();
      t_rotate();
      t_source();
      t_flags();
      t_carry_codes();
      t_zero_codes();
      t_reserved();
      t_source_codes();
      t_sweep();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule